// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver with Receive FIFO

This block receives bytes from a clocked synchronous serial link. The link supplies its own bit clock and a data line. The bit clock is brought into the system clock domain through a flop-chain synchronizer, and its rising edges are detected there. On each detected rising edge, while reception is allowed, one data bit is shifted in, least significant bit first. Every eighth bit completes a byte, and that byte is written into a 16-entry receive FIFO.

Software controls the block through strobed register accesses:

- A control write sets the receive-enable bit and picks one of four fill thresholds.
- A data-read strobe pops the oldest byte.
- The current fill count can be read at any time.
- Two status bits are available:
  - A threshold flag. It is cleared only through a read-then-write-zero handshake.
  - A sticky overrun flag. It halts reception until software writes it back to zero.

An interrupt output pulses once each time the threshold flag goes from 0 to 1.

Top module: `sync_serial_rx`

## Requirements
- R1: Data is sampled on each rising edge of `ser_clk` while reception is allowed, least significant bit first, and every 8 bits form one byte that is written into the FIFO.
- R2: A one-cycle `data_re` strobe removes the oldest stored byte, and `data_q` presents that byte from the cycle after the strobe.
- R3: A `data_re` strobe while the FIFO is empty makes `data_q` zero and leaves `level_q` at zero.
- R4: `level_q` always equals the number of unread bytes held, from 0 to 16.
- R5: The threshold flag, `stat_q[0]`, becomes 1 when `level_q` is at or above the level selected by `ctrl_wdata[2:1]`. The encoding is 0 for 1 byte, 1 for 4 bytes, 2 for 8 bytes and 3 for 14 bytes.
- R6: A `stat_we` with `stat_wdata[0]`=0 clears `stat_q[0]` only if a `stat_re` strobe saw `stat_q[0]`=1 after the previous status write. Without that read, the flag keeps its value.
- R7: A handshake clear attempted while `level_q` is still at or above the selected level leaves `stat_q[0]` at 1.
- R8: `irq` is a one-cycle pulse in the cycle where `stat_q[0]` first reads 1 after reading 0. It is low at every other time.
- R9: A byte that completes while 16 bytes are held is discarded and sets the overrun flag, `stat_q[1]`. The 16 stored bytes stay unchanged and in order.
- R10: While `stat_q[1]` is 1, serial clock edges shift in and store nothing. A `stat_we` with `stat_wdata[1]`=0 clears the flag, and reception then restarts with a fresh byte. Writing 1 to either status bit has no effect.
- R11: A control write with `ctrl_wdata[0]`=0 stops reception. Any partially received bits are dropped, and later serial clock edges store nothing until reception is enabled again.
- R12: After reset the FIFO is empty, both status bits are 0, `irq` is 0, reception is disabled and the selected level is 1 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock from the link |
| ser_data | input | 1 | Serial data line |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Bit 0 is receive enable; bits 2:1 select the threshold |
| stat_re | input | 1 | Status read strobe; arms the threshold-flag clear |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 2 | A 0 in a bit requests a clear of that status bit |
| stat_q | output | 2 | Bit 0 is the threshold flag; bit 1 is the overrun flag |
| data_re | input | 1 | Data read strobe; pops the FIFO |
| data_q | output | 8 | Byte returned by the last data read |
| level_q | output | 5 | Number of unread bytes in the FIFO |
| irq | output | 1 | Pulse on a rising threshold flag |

## Verification
Internal faults show up at the ports in predictable ways:

- A bit counter that is off by one gives rotated or merged bytes. The first `data_q` after a single transfer then shows the wrong value.
- A pointer or count fault gives out-of-order data or a wrong `level_q` within one read.
- A missed freeze during overrun shows up as `level_q` staying at 16 but with the wrong bytes once the FIFO is drained. It can also show up as a byte that arrived during overrun appearing later.
- A broken clear handshake leaves `stat_q[0]` with the wrong value on the cycle after the status write. A second rising edge without an `irq` pulse shows up in the pulse count.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned STAT_THR_BIT = 0;
  localparam int unsigned STAT_OVR_BIT = 1;

  // Control word: en in bit 0, threshold select in bits 2:1
  typedef struct packed {
    logic [1:0] thr_sel;
    logic       en;
  } rx_ctrl_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_data,
  output logic clk_rise,
  output logic data_s
);
  logic [STAGES-1:0] ck_pipe;
  logic [STAGES-1:0] dt_pipe;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_pipe <= '0;
      dt_pipe <= '0;
      ck_last <= 1'b0;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-2:0], ser_clk};
      dt_pipe <= {dt_pipe[STAGES-2:0], ser_data};
      ck_last <= ck_pipe[STAGES-1];
    end
  end

  assign clk_rise = ck_pipe[STAGES-1] & ~ck_last;
  assign data_s   = dt_pipe[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         rise,
  input  logic         sdata,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CNTW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  logic [W-1:0]    sh;
  logic [CNTW-1:0] cnt;

  // Leaving the active state drops any partial byte
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh  <= '0;
      cnt <= '0;
    end else if (rise) begin
      sh  <= {sdata, sh[W-1:1]};
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign done = active & rise & (cnt == LAST);
  assign word = {sdata, sh[W-1:1]};
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (count == CFULL);
  assign wr_ok = push & ~full;
  assign rd_ok = pop & (count != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= rd_ok ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int THR_0       = 1,
  parameter int THR_1       = 4,
  parameter int THR_2       = 8,
  parameter int THR_3       = 14,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ctrl_we,
  input  logic [2:0]        ctrl_wdata,
  input  logic              stat_re,
  input  logic              stat_we,
  input  logic [1:0]        stat_wdata,
  output logic [1:0]        stat_q,
  input  logic              data_re,
  output logic [DATA_W-1:0] data_q,
  output logic [LVL_W-1:0]  level_q,
  output logic              irq
);
  import srx_pkg::*;

  rx_ctrl_t           ctrl_q;
  logic               thr_flag, ovr_flag, armed;
  logic               rx_en, active;
  logic               clk_rise, data_s;
  logic               byte_done, fifo_full;
  logic [DATA_W-1:0]  byte_word;
  logic [LVL_W-1:0]   thr_lvl;
  logic               thr_next, clr_ok;

  assign rx_en  = ctrl_q.en;
  assign active = rx_en & ~ovr_flag;

  always_comb begin
    case (ctrl_q.thr_sel)
      2'd0:    thr_lvl = LVL_W'(THR_0);
      2'd1:    thr_lvl = LVL_W'(THR_1);
      2'd2:    thr_lvl = LVL_W'(THR_2);
      default: thr_lvl = LVL_W'(THR_3);
    endcase
  end

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .clk_rise(clk_rise), .data_s(data_s)
  );

  srx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active), .rise(clk_rise),
    .sdata(data_s), .done(byte_done), .word(byte_word)
  );

  srx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(byte_done), .wdata(byte_word),
    .pop(data_re), .rdata(data_q), .count(level_q), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= rx_ctrl_t'(ctrl_wdata);
  end

  // Overrun: set by a byte arriving to a full FIFO, cleared by writing 0
  always_ff @(posedge clk) begin
    if (rst) ovr_flag <= 1'b0;
    else if (byte_done && fifo_full) ovr_flag <= 1'b1;
    else if (stat_we && !stat_wdata[STAT_OVR_BIT]) ovr_flag <= 1'b0;
  end

  // Clear handshake: a read that sees the flag high arms the next write
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (stat_we) armed <= 1'b0;
    else if (stat_re && thr_flag) armed <= 1'b1;
  end

  assign clr_ok   = stat_we & ~stat_wdata[STAT_THR_BIT] & armed;
  assign thr_next = thr_flag ? ~(clr_ok && (level_q < thr_lvl))
                             : (level_q >= thr_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      thr_flag <= thr_next;
      irq      <= thr_next & ~thr_flag;
    end
  end

  assign stat_q = {ovr_flag, thr_flag};
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       stat_q,
  input logic [LVL_W-1:0] level_q,
  input logic [LVL_W-1:0] thr_lvl,
  input logic             irq,
  input logic             rx_en,
  input logic             armed,
  input logic             data_re,
  input logic [7:0]       data_q
);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_W'(DEPTH));

  assert_thr_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (level_q >= thr_lvl) |=> stat_q[0]);

  assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !armed) |=> stat_q[0]);

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q[0] && !$past(stat_q[0])));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (data_re && level_q == '0) |=> (data_q == 8'h00));

  assert_ovr_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    stat_q[1] |=> (level_q <= $past(level_q)));

  assert_disabled_store_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (level_q <= $past(level_q)));
endmodule

bind sync_serial_rx srx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .stat_q(stat_q), .level_q(level_q),
  .thr_lvl(thr_lvl), .irq(irq), .rx_en(rx_en), .armed(armed),
  .data_re(data_re), .data_q(data_q)
);

// File: tb/sync_serial_rx_bench.sv
module sync_serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0, ser_data = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic       stat_re = 1'b0, stat_we = 1'b0;
  logic [1:0] stat_wdata = 2'b11;
  logic [1:0] stat_q;
  logic       data_re = 1'b0;
  logic [7:0] data_q;
  logic [4:0] level_q;
  logic       irq;

  int n_chk = 0, n_fail = 0, irq_seen = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  sync_serial_rx u_sync_serial_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .stat_re(stat_re),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .data_re(data_re), .data_q(data_q), .level_q(level_q), .irq(irq)
  );

  always @(posedge clk) if (!rst && irq) irq_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic en, input logic [1:0] sel);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = {sel, en};
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_data = b[i];
      idle(4); ser_clk = 1'b1;
      idle(4); ser_clk = 1'b0;
    end
    idle(6);
  endtask

  task automatic read_byte(output logic [7:0] v);
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
    v = data_q;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_re = 1'b1;
    @(negedge clk); stat_re = 1'b0;
  endtask

  task automatic stat_write(input logic [1:0] w);
    @(negedge clk); stat_we = 1'b1; stat_wdata = w;
    @(negedge clk); stat_we = 1'b0; stat_wdata = 2'b11;
  endtask

  task automatic t_reset();
    chk("R12 stat after reset", int'(stat_q), 0);
    chk("R12 level after reset", int'(level_q), 0);
    chk("R12 irq after reset", int'(irq), 0);
    send_bits(8'hFF, 8);
    chk("R12 disabled after reset", int'(level_q), 0);
    read_byte(rd);
    chk("R3 empty read data", int'(rd), 0);
    chk("R3 empty read level", int'(level_q), 0);
  endtask

  task automatic t_basic();
    set_ctrl(1'b1, 2'd0);
    send_bits(8'hA5, 8);
    chk("R4 level one byte", int'(level_q), 1);
    chk("R5 thr flag at 1", int'(stat_q[0]), 1);
    chk("R8 irq pulse count", irq_seen, 1);
    read_byte(rd);
    chk("R1 lsb-first byte", int'(rd), 'hA5);
    chk("R2 pop level", int'(level_q), 0);
    stat_write(2'b10);
    chk("R6 clear without read", int'(stat_q[0]), 1);
    stat_read();
    stat_write(2'b10);
    chk("R6 clear after read", int'(stat_q[0]), 0);
  endtask

  task automatic t_order();
    logic [7:0] v [4] = '{8'h13, 8'hC8, 8'h7E, 8'h01};
    set_ctrl(1'b1, 2'd1);
    for (int i = 0; i < 3; i++) send_bits(v[i], 8);
    chk("R5 below level 4", int'(stat_q[0]), 0);
    send_bits(v[3], 8);
    chk("R5 at level 4", int'(stat_q[0]), 1);
    chk("R8 second pulse", irq_seen, 2);
    stat_read();
    stat_write(2'b10);
    chk("R7 clear while at level", int'(stat_q[0]), 1);
    chk("R4 level four", int'(level_q), 4);
    for (int i = 0; i < 4; i++) begin
      read_byte(rd);
      chk("R2 fifo order", int'(rd), int'(v[i]));
    end
    stat_read();
    stat_write(2'b10);
    chk("R6 clear below level", int'(stat_q[0]), 0);
    read_byte(rd);
    chk("R3 empty read after drain", int'(rd), 0);
    chk("R3 empty level", int'(level_q), 0);
  endtask

  task automatic t_overrun();
    set_ctrl(1'b1, 2'd3);
    for (int i = 0; i < 16; i++) send_bits(8'(i * 7 + 3), 8);
    chk("R4 level full", int'(level_q), 16);
    chk("R5 at level 14", int'(stat_q[0]), 1);
    chk("R8 third pulse", irq_seen, 3);
    chk("R9 no overrun yet", int'(stat_q[1]), 0);
    send_bits(8'hFF, 8);
    chk("R9 overrun set", int'(stat_q[1]), 1);
    chk("R9 level kept", int'(level_q), 16);
    send_bits(8'hEE, 8);
    chk("R10 frozen level", int'(level_q), 16);
    stat_write(2'b11);
    chk("R10 write one keeps", int'(stat_q), 3);
    stat_write(2'b01);
    chk("R10 overrun cleared", int'(stat_q[1]), 0);
    chk("R10 thr untouched", int'(stat_q[0]), 1);
    for (int i = 0; i < 16; i++) begin
      read_byte(rd);
      chk("R9 contents intact", int'(rd), (i * 7 + 3) & 8'hFF);
    end
    send_bits(8'h3C, 8);
    chk("R10 resume level", int'(level_q), 1);
    read_byte(rd);
    chk("R10 resume byte", int'(rd), 'h3C);
    stat_read();
    stat_write(2'b10);
    chk("R6 final clear", int'(stat_q[0]), 0);
  endtask

  task automatic t_disable();
    set_ctrl(1'b1, 2'd3);
    send_bits(8'h0F, 4);
    set_ctrl(1'b0, 2'd3);
    send_bits(8'h99, 8);
    chk("R11 no store disabled", int'(level_q), 0);
    set_ctrl(1'b1, 2'd3);
    send_bits(8'h5A, 8);
    chk("R11 one byte after enable", int'(level_q), 1);
    read_byte(rd);
    chk("R11 partial dropped", int'(rd), 'h5A);
    chk("R8 no extra pulses", irq_seen, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_basic();
    t_order();
    t_overrun();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule